// File: doc/BRIEF.md
# I2C Target Byte Memory with Shared Address Counter

This block is an I2C target that fronts a byte-wide internal memory of 2^ADDR_W locations (4096 by default). It samples SCL and SDA from the system clock and finds START, repeated START and STOP conditions. It matches a 7-bit target address that is set by a parameter. It takes a two-byte word address, stores write data, and shifts read data out MSB first. It drives SDA only through an active-low open-drain enable.

One wrapping address counter serves reads and writes alike. It always holds the location after the last byte that was stored or sent. Three read forms come out of that one counter:
- A read with no address phase continues where the last access stopped.
- A dummy write of the word address, followed by a repeated START, reloads the counter before a read.
- Each controller ACK after a data byte advances the read to the next location, so a single transfer can walk the whole array and wrap.

Top module: `serial_mem_target`

## Requirements
- R1: While reset is asserted and after it is released, `sda_drive_n` is 1 (SDA released) and the block waits for a START.
- R2: A first byte whose upper seven bits equal `DEV_ADDR` is acknowledged (bit 0 is R/W, 1 = read). Any other address gets no acknowledge. The block then acknowledges nothing and changes no state until the next START.
- R3: In a write (R/W=0) the block acknowledges two word-address bytes, high byte first. The low ADDR_W-8 bits of the high byte and all of the low byte form the address, and the remaining high-byte bits are ignored. Each following data byte is acknowledged, stored at the counter address, and the counter then advances by one.
- R4: A random read is a write of the two word-address bytes, then a repeated START and the target address with R/W=1. It returns the byte at the loaded address. The dummy write stores nothing.
- R5: A read with no address phase returns the byte at one past the last location read or written.
- R6: A controller ACK after a read byte makes the block send the byte at the next address. A NACK ends the read, and SDA stays released through the following STOP.
- R7: The counter wraps from 2^ADDR_W-1 to 0 on both reads and writes, and data continues without a break.
- R8: A START at any point abandons the current transfer and begins a new address byte. A partial byte is not stored. STOP returns the block to idle.
- R9: The block changes `sda_drive_n` only while SCL is low, and it releases SDA during the controller's ACK/NACK bit.
- R10: Read data leaves MSB first, one bit per SCL low phase. Write data and address bytes are taken in MSB first on SCL rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus (wired-AND value) |
| sda_drive_n | output | 1 | Open-drain enable: 0 pulls SDA low, 1 releases it |

## Verification
A wrong counter value shows up at the ports on the first data bit of the next read with no address phase, or of the next sequential byte. Such a read returns a byte stored at another location. Distinct, known patterns are therefore placed at neighbouring addresses and at the top of the space, so that an off-by-one or a missing wrap shows up within nine SCL periods. A wrong state in the bit or byte control shows up in the acknowledge slot: a missing ACK, an ACK given to a foreign address, or SDA still held low while the controller sends its ACK bit. A monitor flags any drive change while SCL is high on the cycle it happens.

// File: rtl/smt_pkg.sv
package smt_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_DEV,
      ST_DEV_ACK,
      ST_AHI,
      ST_AHI_ACK,
      ST_ALO,
      ST_ALO_ACK,
      ST_WDAT,
      ST_WDAT_ACK,
      ST_TX,
      ST_TX_ACK
   } smt_state_e;

   localparam int BYTE_W = 8;

endpackage

// File: rtl/smt_bus_sync.sv
module smt_bus_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic [STAGES-1:0] scl_pipe;
   logic [STAGES-1:0] sda_pipe;
   logic              scl_d;
   logic              sda_d;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("smt_bus_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_d    <= 1'b1;
         sda_d    <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
         sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
         scl_d    <= scl_pipe[STAGES-1];
         sda_d    <= sda_pipe[STAGES-1];
      end
   end

   assign scl_s     = scl_pipe[STAGES-1];
   assign sda_s     = sda_pipe[STAGES-1];
   assign scl_rise  = scl_s & ~scl_d;
   assign scl_fall  = ~scl_s & scl_d;
   // SDA moving while SCL stays high marks a bus condition
   assign start_det = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/smt_mem_array.sv
module smt_mem_array #(
   parameter int AW = 12,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);

   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         cells[addr] <= wdata;
      end
   end

   assign rdata = cells[addr];

endmodule

// File: rtl/serial_mem_target.sv
module serial_mem_target
   import smt_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'b1010000,
   parameter int         ADDR_W      = 12,
   parameter int         SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_drive_n
);

   localparam int HI_W = ADDR_W - BYTE_W;

   generate
      if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_addr_w
         $error("serial_mem_target: ADDR_W must lie in 9..16");
      end
   endgenerate

   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

   smt_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   smt_state_e         state;
   logic [2:0]         bitcnt;
   logic [BYTE_W-1:0]  shreg;
   logic               byte_done;
   logic               sda_low;
   logic               dev_ok;
   logic               rw_q;
   logic               got_ack;
   logic [HI_W-1:0]    hi_q;
   logic [ADDR_W-1:0]  ptr;
   logic [BYTE_W-1:0]  rx_byte;
   logic [ADDR_W-1:0]  addr_loaded;
   logic [BYTE_W-1:0]  mem_rdata;
   logic               mem_we;
   logic               rx_state;
   logic               last_rx_bit;

   assign rx_byte     = {shreg[BYTE_W-2:0], sda_s};
   assign rx_state    = (state == ST_DEV) || (state == ST_AHI) ||
                        (state == ST_ALO) || (state == ST_WDAT);
   assign last_rx_bit = rx_state && scl_rise && !byte_done && (bitcnt == 3'd7);

   generate
      if (HI_W == BYTE_W) begin : g_full_hi
         assign addr_loaded = {hi_q, rx_byte};
      end else begin : g_part_hi
         assign addr_loaded = {hi_q[HI_W-1:0], rx_byte};
      end
   endgenerate

   always_comb begin
      mem_we = 1'b0;
      if (!start_det && !stop_det && last_rx_bit && state == ST_WDAT) begin
         mem_we = 1'b1;
      end
   end

   smt_mem_array #(.AW(ADDR_W), .DW(BYTE_W)) u_mem (
      .clk   (clk),
      .wr_en (mem_we),
      .addr  (ptr),
      .wdata (rx_byte),
      .rdata (mem_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         bitcnt    <= '0;
         shreg     <= '0;
         byte_done <= 1'b0;
         sda_low   <= 1'b0;
         dev_ok    <= 1'b0;
         rw_q      <= 1'b0;
         got_ack   <= 1'b0;
         hi_q      <= '0;
         ptr       <= '0;
      end else if (start_det) begin
         state     <= ST_DEV;
         bitcnt    <= '0;
         byte_done <= 1'b0;
         sda_low   <= 1'b0;
      end else if (stop_det) begin
         state     <= ST_IDLE;
         byte_done <= 1'b0;
         sda_low   <= 1'b0;
      end else begin
         case (state)
            ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
               if (scl_rise && !byte_done) begin
                  shreg  <= rx_byte;
                  bitcnt <= bitcnt + 3'd1;
                  if (bitcnt == 3'd7) begin
                     byte_done <= 1'b1;
                     case (state)
                        ST_DEV: begin
                           dev_ok <= (rx_byte[7:1] == DEV_ADDR);
                           rw_q   <= rx_byte[0];
                        end
                        ST_AHI:  hi_q <= rx_byte[HI_W-1:0];
                        ST_ALO:  ptr  <= addr_loaded;
                        ST_WDAT: ptr  <= ptr + 1'b1;
                        default: ;
                     endcase
                  end
               end else if (scl_fall && byte_done) begin
                  byte_done <= 1'b0;
                  if (state == ST_DEV && !dev_ok) begin
                     state <= ST_IDLE;
                  end else begin
                     sda_low <= 1'b1;
                     case (state)
                        ST_DEV:  state <= ST_DEV_ACK;
                        ST_AHI:  state <= ST_AHI_ACK;
                        ST_ALO:  state <= ST_ALO_ACK;
                        default: state <= ST_WDAT_ACK;
                     endcase
                  end
               end
            end
            ST_DEV_ACK, ST_AHI_ACK, ST_ALO_ACK, ST_WDAT_ACK: begin
               if (scl_fall) begin
                  sda_low <= 1'b0;
                  bitcnt  <= '0;
                  case (state)
                     ST_DEV_ACK: begin
                        if (rw_q) begin
                           state   <= ST_TX;
                           shreg   <= mem_rdata;
                           sda_low <= ~mem_rdata[BYTE_W-1];
                           ptr     <= ptr + 1'b1;
                        end else begin
                           state <= ST_AHI;
                        end
                     end
                     ST_AHI_ACK: state <= ST_ALO;
                     default:    state <= ST_WDAT;
                  endcase
               end
            end
            ST_TX: begin
               if (scl_fall) begin
                  if (bitcnt == 3'd7) begin
                     sda_low <= 1'b0;
                     state   <= ST_TX_ACK;
                  end else begin
                     shreg   <= {shreg[BYTE_W-2:0], 1'b0};
                     sda_low <= ~shreg[BYTE_W-2];
                     bitcnt  <= bitcnt + 3'd1;
                  end
               end
            end
            ST_TX_ACK: begin
               if (scl_rise) begin
                  got_ack <= ~sda_s;
               end else if (scl_fall) begin
                  if (got_ack) begin
                     state   <= ST_TX;
                     shreg   <= mem_rdata;
                     sda_low <= ~mem_rdata[BYTE_W-1];
                     ptr     <= ptr + 1'b1;
                     bitcnt  <= '0;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign sda_drive_n = ~sda_low;

   // R9
   sda_edge_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_low) |-> !scl_s);

   // R9
   ctl_ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_TX_ACK) |-> !sda_low);

   // R2
   foreign_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DEV_ACK) |-> dev_ok);

   // R8
   start_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (state == ST_DEV) && !sda_low && (bitcnt == 3'd0));

   // R8
   stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_det && !start_det) |=> (state == ST_IDLE) && !sda_low);

endmodule

// File: tb/tb_serial_mem_target.sv
module tb_serial_mem_target;

   localparam int         Q   = 10;
   localparam logic [6:0] DEV = 7'b1010000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic sda_ctl = 1'b1;
   logic sda_bus;
   logic sda_drive_n;

   int n_chk = 0;
   int n_fail = 0;
   int r9_viol = 0;
   bit finished = 1'b0;

   logic [7:0]  ref_mem [4096];
   logic [11:0] ref_ptr;
   logic [7:0]  wbuf [8];
   logic        prev_dn = 1'b1;

   always #5 clk = ~clk;

   assign sda_bus = sda_ctl & sda_drive_n;

   serial_mem_target dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_i       (scl),
      .sda_i       (sda_bus),
      .sda_drive_n (sda_drive_n)
   );

   // R9 monitor: the drive enable may move only while SCL is low
   always @(negedge clk) begin
      if (rst_n && scl && (sda_drive_n !== prev_dn)) r9_viol++;
      prev_dn = sda_drive_n;
   end

   function automatic logic [11:0] word_addr(logic [7:0] hi, logic [7:0] lo);
      return {hi[3:0], lo};
   endfunction

   function automatic logic [11:0] next_addr(logic [11:0] a);
      return a + 12'd1;
   endfunction

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_start;
      sda_ctl = 1'b1; tick(Q);
      scl = 1'b1;     tick(Q);
      sda_ctl = 1'b0; tick(Q);
      scl = 1'b0;     tick(Q);
   endtask

   task automatic bus_stop;
      sda_ctl = 1'b0; tick(Q);
      scl = 1'b1;     tick(Q);
      sda_ctl = 1'b1; tick(Q);
   endtask

   task automatic clk_bit(input bit b, output bit seen);
      sda_ctl = b; tick(Q);
      scl = 1'b1;  tick(Q);
      seen = sda_bus;
      tick(Q);
      scl = 1'b0;  tick(Q);
   endtask

   task automatic put_byte(input logic [7:0] v, output bit acked);
      bit s;
      for (int i = 7; i >= 0; i--) clk_bit(v[i], s);
      clk_bit(1'b1, s);
      acked = !s;
   endtask

   task automatic get_byte(input bit give_ack, output logic [7:0] v);
      bit s;
      for (int i = 7; i >= 0; i--) begin
         clk_bit(1'b1, s);
         v[i] = s;
      end
      clk_bit(!give_ack, s);
      // R9: the bus must carry the controller's own ACK/NACK bit
      chk(s == !give_ack, "R9 release in ctl ack", int'(s), int'(!give_ack));
   endtask

   task automatic addr_phase(input logic [7:0] hi, input logic [7:0] lo);
      bit a;
      bus_start;
      put_byte({DEV, 1'b0}, a); chk(a, "R2 ack own addr (write)", int'(a), 1);
      put_byte(hi, a);          chk(a, "R3 ack addr hi", int'(a), 1);
      put_byte(lo, a);          chk(a, "R3 ack addr lo", int'(a), 1);
   endtask

   task automatic do_write(input logic [7:0] hi, input logic [7:0] lo, input int n);
      bit a;
      logic [11:0] ad;
      addr_phase(hi, lo);
      ad = word_addr(hi, lo);
      for (int k = 0; k < n; k++) begin
         put_byte(wbuf[k], a);
         chk(a, "R3 ack data", int'(a), 1);
         ref_mem[ad] = wbuf[k];
         ad = next_addr(ad);
      end
      bus_stop;
      ref_ptr = ad;
   endtask

   task automatic do_read(input bit random, input logic [7:0] hi, input logic [7:0] lo,
                          input int n, input string tag);
      bit a;
      logic [7:0] v;
      if (random) begin
         addr_phase(hi, lo);
         ref_ptr = word_addr(hi, lo);
      end
      bus_start;
      put_byte({DEV, 1'b1}, a);
      chk(a, "R2 ack own addr (read)", int'(a), 1);
      for (int k = 0; k < n; k++) begin
         get_byte(k != n - 1, v);
         chk(v === ref_mem[ref_ptr], tag, int'(v), int'(ref_mem[ref_ptr]));
         ref_ptr = next_addr(ref_ptr);
      end
      bus_stop;
      chk(sda_drive_n == 1'b1, "R6 released after NACK+STOP", int'(sda_drive_n), 1);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      bit a;
      bit s;
      logic [7:0] v;
      void'($urandom(32'd1320));

      // R1: reset state
      tick(5);
      chk(sda_drive_n == 1'b1, "R1 released in reset", int'(sda_drive_n), 1);
      rst_n = 1'b1;
      tick(10);
      chk(sda_drive_n == 1'b1, "R1 released after reset", int'(sda_drive_n), 1);

      // R3: write six bytes, junk in the upper bits of the high address byte
      wbuf[0] = 8'h01; wbuf[1] = 8'h80; wbuf[2] = 8'hC3;
      wbuf[3] = 8'h5A; wbuf[4] = 8'h7E; wbuf[5] = 8'h12;
      do_write(8'hF3, 8'hA5, 6);

      // R4 and R10: random read with different junk upper bits, 0x01 then 0x80
      do_read(1'b1, 8'h53, 8'hA5, 2, "R10 MSB first / R4 random read");
      // R5: current-address read continues at 0x3A7
      do_read(1'b0, 8'h00, 8'h00, 1, "R5 current address read");
      // R6: sequential read of the next three bytes
      do_read(1'b0, 8'h00, 8'h00, 3, "R6 sequential read");

      // R2: foreign target address is ignored, counter untouched (0x3AB? no: 0x3AB unknown)
      ref_ptr = 12'h3A9;
      do_read(1'b1, 8'h03, 8'hA8, 1, "R4 reload before foreign test");
      bus_start;
      put_byte({7'h51, 1'b0}, a); chk(!a, "R2 no ack foreign addr", int'(a), 0);
      put_byte(8'h03, a);         chk(!a, "R2 no ack after foreign", int'(a), 0);
      put_byte(8'h00, a);         chk(!a, "R2 no ack after foreign", int'(a), 0);
      bus_stop;
      do_read(1'b0, 8'h00, 8'h00, 1, "R2 counter unchanged by foreign addr");

      // R4: dummy write to 0x3A7 with repeated START stores nothing
      do_read(1'b1, 8'h03, 8'hA7, 1, "R4 dummy write stores nothing");

      // R8: START in the middle of a data byte abandons it
      addr_phase(8'h03, 8'hA6);
      clk_bit(1'b1, s); clk_bit(1'b1, s); clk_bit(1'b1, s);
      ref_ptr = 12'h3A6;
      do_read(1'b0, 8'h00, 8'h00, 1, "R8 partial byte not stored");

      // R7: write across the top of the space, then read across it
      wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC4; wbuf[3] = 8'hD8; wbuf[4] = 8'hE0;
      do_write(8'h0F, 8'hFE, 5);
      chk(ref_ptr == 12'h003, "R7 write wrap pointer model", int'(ref_ptr), 3);
      do_read(1'b1, 8'hAF, 8'hFE, 4, "R7 sequential wrap read");
      do_read(1'b0, 8'h00, 8'h00, 1, "R7 current read after wrap");

      // random mix of writes and read-backs
      for (int it = 0; it < 8; it++) begin
         logic [31:0] rv;
         logic [11:0] ad;
         int n;
         rv = $urandom();
         ad = rv[11:0];
         n  = 1 + int'(rv[13:12]) % 3;
         for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom());
         do_write({rv[19:16], ad[11:8]}, ad[7:0], n);
         do_read(1'b1, {rv[23:20], ad[11:8]}, ad[7:0], n, "R3 R6 random write/read-back");
      end

      // R9: no drive change while SCL high over the whole run
      chk(r9_viol == 0, "R9 SDA changed while SCL high", r9_viol, 0);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule